// File: doc/BRIEF.md
# Chainable Four-Bit Preset Counter

This block is a synchronous binary up-counter built from identical four-bit slices. Each slice counts in natural binary. It has an active-low clear that acts at once, without waiting for a clock edge. It has an active-low parallel load that takes effect on the rising clock edge. It has two count enables, and it drives a carry output. The carry is meant to drive an enable of the next slice, so slices chain into a wider counter with no added gates.

The top level chains `N_SLICES` slices into one counter of `4*N_SLICES` bits. All slices share the clock, clear, load and data bus.

- The lowest slice takes the global enable on both of its enables.
- Every higher slice takes the global enable on its run enable. It takes the carry of the slice below on its chain enable.
- The carry of the last slice comes out as a terminal-count flag.

Each slice picks one operation per edge, named by the enumeration in the package:

- `OP_LOAD`: the load input is low.
- `OP_COUNT`: load is high and both enables are high.
- `OP_HOLD`: every other case.

Clear overrides all three, because it resets the register asynchronously. The possible moves are load to any value, increment (with 15 wrapping to 0), and hold.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `q` is all zeros. This holds from the moment `clr_n` falls, without any clock edge, and `clr_n` low overrides a load or count that is requested at an edge.
- R2: When `load_n` is low at a rising edge and `clr_n` is high, `q` takes the value of `din` after that edge. This happens whatever the value of `cnt_en`, and load wins over counting.
- R3: When `load_n` is high and `cnt_en` is high at a rising edge, `q` read as an unsigned binary number increases by exactly one.
- R4: When `load_n` is high and `cnt_en` is low at a rising edge, `q` keeps its value.
- R5: Inside one slice, an enabled count from 15 (4'b1111) goes to 0. Each slice's count advances only when its run enable and its chain enable are both high.
- R6: A slice's carry is high exactly when its count is 15 and its chain enable is high. The run enable has no effect on carry. At the top, `term_cnt` is high exactly when every bit of `q` is 1 and `cnt_en` is high, and it follows `cnt_en` without a clock edge.
- R7: A slice above the lowest advances only on an edge at which every lower slice holds 15 and `cnt_en` is high. An enabled count from all ones wraps the full `q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| cnt_en | input | 1 | Global count enable |
| din | input | 4*N_SLICES | Parallel load value |
| q | output | 4*N_SLICES | Count value |
| term_cnt | output | 1 | High when the count is all ones and counting is enabled |

## Verification
The functions that can meet in the same edge are load and count. The bench holds `cnt_en` high while it pulses `load_n`, including at values where a carry ripples through every slice, and expects the loaded value and not the incremented one. A second collision is clear against load: `clr_n` is pulled low between edges while a load is pending. The bench expects zero at once, before the edge, and still zero after it. Every cycle is judged against an integer model of the whole counter.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
    localparam int SLICE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2
    } slice_op_e;
endpackage

// File: rtl/slice_op_decode.sv
module slice_op_decode
    import cascade_counter_pkg::*;
(
    input  logic      load_n,
    input  logic      en_run,
    input  logic      en_chain,
    output slice_op_e op
);
    always_comb begin
        if (!load_n)
            op = OP_LOAD;
        else if (en_run && en_chain)
            op = OP_COUNT;
        else
            op = OP_HOLD;
    end

    // R2
    always_comb begin
        load_prio_chk: assert (load_n || op == OP_LOAD);
    end
endmodule

// File: rtl/counter_slice.sv
module counter_slice
    import cascade_counter_pkg::*;
(
    input  logic               clk,
    input  logic               clr_n,
    input  logic               load_n,
    input  logic               en_run,
    input  logic               en_chain,
    input  logic [SLICE_W-1:0] din,
    output logic [SLICE_W-1:0] q,
    output logic               carry
);
    localparam logic [SLICE_W-1:0] TOP_VAL = {SLICE_W{1'b1}};

    slice_op_e                op;
    logic      [SLICE_W-1:0]  q_r;

    slice_op_decode u_dec (
        .load_n   (load_n),
        .en_run   (en_run),
        .en_chain (en_chain),
        .op       (op)
    );

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q_r <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  q_r <= din;
                OP_COUNT: q_r <= q_r + 1'b1;
                default:  q_r <= q_r;
            endcase
        end
    end

    assign q     = q_r;
    assign carry = (q_r == TOP_VAL) && en_chain;

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_run && en_chain && q != TOP_VAL) |=> q == $past(q) + 1'b1);

    // R4
    hold_keep_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_run && en_chain)) |=> $stable(q));

    // R5
    slice_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_run && en_chain && q == TOP_VAL) |=> q == '0);

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> q == '0);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int N_SLICES = 3
) (
    input  logic                          clk,
    input  logic                          clr_n,
    input  logic                          load_n,
    input  logic                          cnt_en,
    input  logic [SLICE_W*N_SLICES-1:0]   din,
    output logic [SLICE_W*N_SLICES-1:0]   q,
    output logic                          term_cnt
);
    localparam int TOTAL_W = SLICE_W * N_SLICES;

    logic [N_SLICES-1:0] chain_en;
    logic [N_SLICES-1:0] carry;

    for (genvar k = 0; k < N_SLICES; k++) begin : g_slice
        if (k == 0) begin : g_first
            assign chain_en[k] = cnt_en;
        end else begin : g_upper
            assign chain_en[k] = carry[k-1];
        end

        counter_slice u_slice (
            .clk      (clk),
            .clr_n    (clr_n),
            .load_n   (load_n),
            .en_run   (cnt_en),
            .en_chain (chain_en[k]),
            .din      (din[k*SLICE_W +: SLICE_W]),
            .q        (q[k*SLICE_W +: SLICE_W]),
            .carry    (carry[k])
        );
    end

    assign term_cnt = carry[N_SLICES-1];

    // R6
    term_ones_chk: assert property (@(posedge clk) disable iff (!clr_n)
        term_cnt |-> (q == {TOTAL_W{1'b1}} && cnt_en));

    // R7
    full_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (term_cnt && load_n) |=> q == '0);

    // R7
    upper_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && q[SLICE_W-1:0] == {SLICE_W{1'b1}}))
        |=> $stable(q[TOTAL_W-1:SLICE_W]));
endmodule

// File: tb/test_cascade_counter.sv
module test_cascade_counter;
    localparam int  N_SLICES = 3;
    localparam int  W        = 4 * N_SLICES;
    localparam time CLK_T    = 10;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         load_n;
    logic         cnt_en;
    logic [W-1:0] din;
    logic [W-1:0] q;
    logic         term_cnt;

    logic [W-1:0] model;
    int           n_cmp = 0;
    int           n_bad = 0;
    string        tag   = "R1";

    cascade_counter #(.N_SLICES(N_SLICES)) i_cascade_counter (
        .clk      (clk),
        .clr_n    (clr_n),
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .din      (din),
        .q        (q),
        .term_cnt (term_cnt)
    );

    always #(CLK_T/2) clk = ~clk;

    // Behavioural reference: one integer for the whole counter.
    always @(posedge clk or negedge clr_n) begin
        if (!clr_n)      model <= '0;
        else if (!load_n) model <= din;
        else if (cnt_en)  model <= model + 1;
    end

    task automatic compare(input string req);
        logic exp_t;
        exp_t = (model == {W{1'b1}}) && cnt_en;
        n_cmp++;
        if (q !== model) begin
            n_bad++;
            $display("FAIL %s q: got %h expected %h", req, q, model);
        end
        n_cmp++;
        if (term_cnt !== exp_t) begin
            n_bad++;
            $display("FAIL R6 term_cnt (%s): got %b expected %b", req, term_cnt, exp_t);
        end
    endtask

    task automatic step(input logic ld, input logic en, input logic [W-1:0] d);
        load_n = ld;
        cnt_en = en;
        din    = d;
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_T * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        clr_n  = 1'b0;
        load_n = 1'b1;
        cnt_en = 1'b0;
        din    = '0;
        repeat (2) @(negedge clk);
        tag = "R1";
        compare(tag);
        clr_n = 1'b1;

        // R2 load with enable low, then R4 hold
        tag = "R2"; step(1'b0, 1'b0, 12'hABC);
        tag = "R4"; step(1'b1, 1'b0, 12'h123);
        step(1'b1, 1'b0, 12'h000);
        // R3 plain counting
        tag = "R3";
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 12'h000);
        // R2 load wins over count
        tag = "R2"; step(1'b0, 1'b1, 12'h0FE);
        // R5 / R7 low slice wraps, carry into middle slice
        tag = "R5";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 12'h000);
        // R6 term_cnt follows cnt_en without an edge
        tag = "R6"; step(1'b0, 1'b0, 12'hFFF);
        cnt_en = 1'b1; #1; compare("R6");
        cnt_en = 1'b0; #1; compare("R6");
        // R7 full wrap
        tag = "R7";
        step(1'b1, 1'b1, 12'h000);
        step(1'b1, 1'b1, 12'h000);
        // R7 load while ripple pending, count enabled
        tag = "R7"; step(1'b0, 1'b1, 12'hEFF);
        step(1'b0, 1'b1, 12'h5FF);
        step(1'b1, 1'b1, 12'h000);

        // R1 clear between edges against pending load
        tag = "R1";
        load_n = 1'b0; din = 12'h777; cnt_en = 1'b1;
        clr_n = 1'b0; #1; compare("R1");
        @(negedge clk); compare("R1");
        clr_n = 1'b1;

        // Random patterns
        tag = "R3";
        for (int i = 0; i < 400; i++) begin
            logic ld;
            ld = ($urandom_range(0, 15) == 0) ? 1'b0 : 1'b1;
            step(ld, logic'($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 1) == 1) ? 12'hFFD : W'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule